// File: doc/BRIEF.md
# Pulse-Width Modulator with Binary Rate Multiplier

This block produces one pulse-width modulated output whose effective resolution is eight bits, although it runs only a 5-bit period counter. The upper five bits of the data value set a coarse pulse width in system clocks within a 32-clock period. The lower three bits drive a binary rate multiplier (BRM). The BRM stretches the high time of selected periods by one clock, inside a frame of eight periods. The averaged duty is therefore (8·N + B) / 256, where N is the coarse width and B is the BRM value.

A new data value is captured in a shadow register when it is written. It takes effect only when the next frame begins, so no frame ever mixes two settings. An enable input passes the pin to the modulator. While the enable is low, the output-enable is deasserted so that general-purpose logic can own the pin. The counters keep running while the channel is disabled, so the phase is kept.

Top module: `brm_pwm`

## Requirements
- R1: An active-low reset clears the period counter, the frame counter, the shadow value and the active value. While reset is held, pwm_out is low. After reset is released, the output stays low until a written value reaches the active register.
- R2: One period is 32 system clocks. Within a period the output is high for the first N clocks (clock indices 0 to N-1), where N is the active value's bits [7:3].
- R3: With an active value of zero, the output stays low for every clock of every period.
- R4: Over one frame of 8 consecutive periods, the total high time is 8·N + B clocks, where B is bits [2:0] of the active value.
- R5: Each extra BRM pulse is exactly one clock long. It sits at clock index N of its period, directly after the main pulse. When N = 0 it is a lone one-clock pulse at index 0.
- R6: The BRM pulses are spread using the 3-bit frame index F (0 to 7, counting periods within the frame). Bit 2 of B adds a pulse in periods where F[0] = 1. Bit 1 adds a pulse where F[1:0] = 2'b10. Bit 0 adds a pulse where F = 3'b100. No period gets more than one extra clock.
- R7: A write loads only the shadow register. The active value changes only at the edge that ends the last clock of frame period 7. A write in the middle of a frame leaves the rest of that frame unchanged.
- R8: A write that happens on that same final edge of a frame does not reach the frame that follows. The following frame uses the shadow value from before the write, and the written value takes effect one frame later.
- R9: While enable is low, both pwm_out and pwm_oe are low. The period and frame counters keep advancing. When enable returns high, the waveform resumes at the phase the counters have reached.
- R10: With N = 31 and B = 7, period 7 of the frame is high for all 32 clocks, and the other periods are high for 31 or 32 clocks as R6 dictates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the period counter advances every cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Loads wr_data into the shadow register on this edge |
| wr_data | input | 8 | Data value: [7:3] coarse width, [2:0] BRM count |
| enable | input | 1 | Channel enable; low hands the pin back to general-purpose use |
| pwm_out | output | 1 | Modulated output, forced low while disabled |
| pwm_oe | output | 1 | Pin drive enable, equal to enable |

## Verification
A fault in the period counter moves or stretches the edge of the main pulse, and it shows within one 32-clock period as a high count other than N or N+1. A fault in the frame counter or in the BRM decode moves extra pulses into the wrong periods. This shows up in the per-period counts within one 256-clock frame, even where the frame total still matches. An active register that reloads at the wrong moment shows as a setting that changes partway through a frame, visible at the first period after the stray load. A shadow path that is skipped shows as a write arriving one frame too early.

// File: rtl/brm_pwm.sv
module brm_pwm #(
  parameter int PW = 5,
  parameter int BW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PW+BW-1:0] wr_data,
  input  logic             enable,
  output logic             pwm_out,
  output logic             pwm_oe
);
  localparam int DW = PW + BW;

  logic [PW-1:0] pcnt;
  logic [BW-1:0] fcnt;
  logic [DW-1:0] shadow, act;
  logic          brm_hit, sel, wave;

  wire [PW-1:0] width      = act[DW-1:BW];
  wire [BW-1:0] rate       = act[BW-1:0];
  wire          period_end = &pcnt;
  wire          frame_end  = period_end & (&fcnt);

  // rate bit k fires where the frame index ends in a one followed by BW-1-k zeros
  always_comb begin
    brm_hit = 1'b0;
    sel     = 1'b0;
    for (int k = 0; k < BW; k++) begin
      sel = rate[k] & fcnt[BW-1-k];
      for (int i = 0; i < BW - 1 - k; i++) sel = sel & ~fcnt[i];
      brm_hit = brm_hit | sel;
    end
  end

  assign wave    = (pcnt < width) | ((pcnt == width) & brm_hit);
  assign pwm_oe  = enable;
  assign pwm_out = enable & wave;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt   <= '0;
      fcnt   <= '0;
      shadow <= '0;
      act    <= '0;
    end else begin
      pcnt <= pcnt + 1'b1;
      if (period_end) fcnt <= fcnt + 1'b1;
      if (wr_en) shadow <= wr_data;
      if (frame_end) act <= shadow;
    end
  end

  assert_period_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pcnt == $past(pcnt) + 1'b1);

  assert_late_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pcnt > width) |-> !pwm_out);

  assert_zero_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (act == '0) |-> !pwm_out);

  assert_act_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(act));

  assert_frame_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(fcnt));

  assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!pwm_out && !pwm_oe));
endmodule

// File: tb/tb_brm_pwm.sv
module tb_brm_pwm;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic enable = 1'b1;
  logic pwm_out, pwm_oe;

  always #5 clk = ~clk;

  brm_pwm dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
               .enable(enable), .pwm_out(pwm_out), .pwm_oe(pwm_oe));

  int n_chk = 0, n_fail = 0;
  int mp = 0, mf = 0;
  logic [7:0] msh = 8'h00, mact = 8'h00;
  int per_hi = 0, frm_hi = 0;
  bit per_ok = 1, frm_ok = 1;
  bit done = 0;

  function automatic bit brm_on(logic [2:0] b, int f);
    logic [2:0] fi;
    fi = f[2:0];
    return (b[2] && fi[0]) || (b[1] && fi[1:0] == 2'b10) || (b[0] && fi == 3'b100);
  endfunction

  function automatic bit exp_bit(logic [7:0] d, int p, int f);
    int n;
    n = int'(d[7:3]);
    return (p < n) || (p == n && brm_on(d[2:0], f));
  endfunction

  task automatic chk(bit ok, string tag, int actual, int expected);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (period %0d frame %0d)", tag, actual, expected, mp, mf);
    end
  endtask

  task automatic sample(string tag);
    bit e;
    e = enable ? exp_bit(mact, mp, mf) : 1'b0;
    chk(pwm_out === e, tag, int'(pwm_out), int'(e));
    chk(pwm_oe === enable, "R9", int'(pwm_oe), int'(enable));
    if (!enable) begin per_ok = 0; frm_ok = 0; end
    per_hi += int'(pwm_out);
    frm_hi += int'(pwm_out);
    if (mp == 31) begin
      if (per_ok)
        chk(per_hi == int'(mact[7:3]) + int'(brm_on(mact[2:0], mf)), "R6", per_hi,
            int'(mact[7:3]) + int'(brm_on(mact[2:0], mf)));
      if (mf == 7 && frm_ok)
        chk(frm_hi == 8 * int'(mact[7:3]) + int'(mact[2:0]), "R4", frm_hi,
            8 * int'(mact[7:3]) + int'(mact[2:0]));
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    if (mp == 31 && mf == 7) mact = msh;
    if (wr_en) msh = wr_data;
    if (mp == 31) begin
      mf = (mf + 1) % 8;
      per_hi = 0; per_ok = 1;
      if (mf == 0) begin frm_hi = 0; frm_ok = 1; end
    end
    mp = (mp + 1) % 32;
    @(negedge clk);
    sample(tag);
  endtask

  task automatic write(logic [7:0] d, string tag);
    wr_en = 1'b1; wr_data = d;
    step(tag);
    wr_en = 1'b0;
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic to_frame_last;
    while (!(mp == 31 && mf == 7)) step("R2");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pwm_out === 1'b0, "R1", int'(pwm_out), 0);
    rst_n = 1'b1;
    sample("R1");
    run(300, "R1");

    // N = 0 with all BRM bits: lone one-clock pulses at index 0
    write(8'h07, "R3");
    to_frame_last();
    step("R5");
    run(255, "R5");

    // mid-frame write must not disturb the running frame
    write(8'h5A, "R2");
    to_frame_last();
    step("R2");
    run(100, "R7");
    write(8'hA5, "R7");
    to_frame_last();
    run(512, "R7");

    // write on the final edge of a frame lands one frame later
    write(8'h31, "R2");
    to_frame_last();
    step("R2");
    to_frame_last();
    write(8'hFF, "R8");
    to_frame_last();
    step("R8");
    to_frame_last();
    run(512, "R10");

    // disable keeps the phase
    enable = 1'b0;
    run(100, "R9");
    enable = 1'b1;
    run(400, "R9");

    // random traffic
    for (int i = 0; i < 30 * 256; i++) begin
      if ($urandom_range(0, 63) == 0) write(8'($urandom_range(0, 255)), "R2");
      else begin
        if ($urandom_range(0, 127) == 0) enable = ~enable;
        step("R2");
      end
    end
    enable = 1'b1;
    write(8'h00, "R3");
    to_frame_last();
    step("R3");
    run(300, "R3");

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule